// File: doc/BRIEF.md
# Five-Stage In-Order Integer Core

A compact in-order processor core with fetch, decode/register-read, execute, memory and writeback stages. Eight 32-bit general registers sit beside a separate link register. Instruction and data storage are word-addressed arrays held inside the block. A program is written into instruction storage through a load port while the core is held in reset. When reset is released, the core fetches from address 20000 and runs until a HALT instruction retires.

Data hazards are covered by forwarding into the execute stage from the memory and writeback stages. The one exception is a load followed at once by an instruction that reads the loaded register, which costs one stall cycle. Branches and jumps resolve in execute, and a taken transfer discards the two younger instructions. The core exposes a halted flag and debug read paths for the fetch PC, any general register, the link register and any data word.

Top module: `inord5_core`

## Requirements
- R1: While reset is asserted, the fetch PC reads 20000, halted is 0, and every general register and the link register read 0.
- R2: An instruction word holds the opcode in bits [31:27], rd in [26:24], rs1 in [23:21], rs2 in [20:18] and a signed literal in [15:0]. The opcodes are NOP=0, ADD=1, SUB=2, MOVC=3, MUL=4, AND=5, OR=6, XOR=7, LOAD=8, STORE=9, BZ=10, BNZ=11, JUMP=12, BAL=13 and HALT=14. Any other opcode acts as NOP. The word at fetch address A is program word A-20000, and sequential fetch advances the PC by 1.
- R3: ADD, SUB, AND, OR and XOR write the result of rs1 op rs2 to rd. MUL writes the low 32 bits of the product. MOVC writes the sign-extended literal. All of these complete in execute in one cycle.
- R4: LOAD writes data word [rs1+literal] to rd. STORE writes rs2 to data word [rs1+literal]. Data words span 0 to DMEM_WORDS-1; a store outside that span is dropped and a load from outside it returns 0.
- R5: An instruction that reads a register written by any of the three instructions before it sees the new value, with no delay unless R6 applies.
- R6: When an instruction reads a register that the LOAD directly ahead of it writes, decode stalls for exactly one cycle. A program that executes n instructions (counting HALT), with s such stalls and t taken transfers, raises halted on clock edge n+4+s+2t after reset is released.
- R7: BZ is taken when the zero flag is set and BNZ when it is clear. The flag holds whether the result of the latest executed ADD, SUB, MOVC, MUL, AND, OR or XOR was zero (a LOAD leaves it unchanged). A taken BZ or BNZ goes to its own address plus the literal.
- R8: JUMP goes to rs1 plus the literal. Every taken transfer turns the two younger instructions into bubbles, so they change no register or memory.
- R9: BAL writes its own address plus 1 into the link register and goes to rs1 plus the literal.
- R10: halted rises one edge after HALT reaches writeback and stays high until reset. All older instructions take effect and no younger one does. The PC then rests at the HALT address plus 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prog_we | input | 1 | Write strobe for instruction storage |
| prog_addr | input | 32 | Instruction word offset from the base address |
| prog_data | input | 32 | Instruction word to store |
| dbg_reg_sel | input | 3 | General register selected for debug read |
| dbg_mem_addr | input | 32 | Data word address for debug read |
| halted | output | 1 | HALT has retired |
| dbg_pc | output | 32 | Current fetch PC |
| dbg_reg_data | output | 32 | Value of the selected general register |
| dbg_link | output | 32 | Value of the link register |
| dbg_mem_data | output | 32 | Data word at dbg_mem_addr (0 outside the span) |

## Verification
The only result whose timing matters at the ports is halted. It is due on edge n+4+s+2t after reset release, where the bench's own instruction-level model counts the executed instructions n, the load-use stalls s and the taken transfers t. The bench counts edges from release until it sees halted on a falling edge and compares that count with the model's. Register, link and memory values are architectural, so they are read through the debug ports only after halted has risen and every stage has drained. Per-cycle PC motion during stalls, redirects and halt is checked by the bound assertions on the cycle after each event.

// File: rtl/inord5_pkg.sv
package inord5_pkg;
  typedef logic [31:0] word_t;

  typedef enum logic [4:0] {
    OP_NOP = 5'd0, OP_ADD = 5'd1, OP_SUB = 5'd2, OP_MOVC = 5'd3,
    OP_MUL = 5'd4, OP_AND = 5'd5, OP_OR = 5'd6, OP_XOR = 5'd7,
    OP_LOAD = 5'd8, OP_STORE = 5'd9, OP_BZ = 5'd10, OP_BNZ = 5'd11,
    OP_JUMP = 5'd12, OP_BAL = 5'd13, OP_HALT = 5'd14
  } op_e;

  function automatic op_e f_op(input word_t w);
    if (w[31:27] <= 5'd14) return op_e'(w[31:27]);
    return OP_NOP;
  endfunction

  function automatic logic [2:0] f_rd(input word_t w);
    return w[26:24];
  endfunction

  function automatic logic [2:0] f_rs1(input word_t w);
    return w[23:21];
  endfunction

  function automatic logic [2:0] f_rs2(input word_t w);
    return w[20:18];
  endfunction

  function automatic word_t f_imm(input word_t w);
    return {{16{w[15]}}, w[15:0]};
  endfunction

  function automatic logic f_is_alu(input op_e op);
    return op inside {OP_ADD, OP_SUB, OP_MOVC, OP_MUL, OP_AND, OP_OR, OP_XOR};
  endfunction

  function automatic logic f_writes(input op_e op);
    return f_is_alu(op) || (op == OP_LOAD);
  endfunction

  function automatic logic f_uses_rs1(input op_e op);
    return op inside {OP_ADD, OP_SUB, OP_MUL, OP_AND, OP_OR, OP_XOR,
                      OP_LOAD, OP_STORE, OP_JUMP, OP_BAL};
  endfunction

  function automatic logic f_uses_rs2(input op_e op);
    return op inside {OP_ADD, OP_SUB, OP_MUL, OP_AND, OP_OR, OP_XOR, OP_STORE};
  endfunction

  function automatic word_t f_alu(input op_e op, input word_t a, input word_t b,
                                  input word_t imm);
    word_t prod;
    prod = a * b;
    case (op)
      OP_ADD:  return a + b;
      OP_SUB:  return a - b;
      OP_MOVC: return imm;
      OP_MUL:  return prod;
      OP_AND:  return a & b;
      OP_OR:   return a | b;
      OP_XOR:  return a ^ b;
      default: return a + imm;
    endcase
  endfunction
endpackage

// File: rtl/inord5_regfile.sv
module inord5_regfile #(
  parameter int NREG = 8,
  parameter int W    = 32,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr_a,
  input  logic [AW-1:0] raddr_b,
  output logic [W-1:0]  rdata_a,
  output logic [W-1:0]  rdata_b,
  input  logic [AW-1:0] dbg_sel,
  output logic [W-1:0]  dbg_data
);
  logic [W-1:0] regs [NREG];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (we) begin
      regs[waddr] <= wdata;
    end
  end

  // same-cycle writeback bypass into the decode read
  assign rdata_a  = (we && waddr == raddr_a) ? wdata : regs[raddr_a];
  assign rdata_b  = (we && waddr == raddr_b) ? wdata : regs[raddr_b];
  assign dbg_data = regs[dbg_sel];
endmodule

// File: rtl/inord5_hazard.sv
module inord5_hazard
  import inord5_pkg::*;
(
  input  logic       fd_valid,
  input  op_e        fd_op,
  input  logic [2:0] fd_rs1,
  input  logic [2:0] fd_rs2,
  input  logic       de_valid,
  input  op_e        de_op,
  input  logic [2:0] de_rd,
  input  logic [2:0] de_rs1,
  input  logic [2:0] de_rs2,
  input  word_t      de_a,
  input  word_t      de_b,
  input  logic       em_valid,
  input  logic       em_wr,
  input  op_e        em_op,
  input  logic [2:0] em_rd,
  input  word_t      em_res,
  input  logic       mw_valid,
  input  logic       mw_wr,
  input  logic [2:0] mw_rd,
  input  word_t      mw_val,
  output logic       ld_stall,
  output word_t      opa,
  output word_t      opb
);
  logic em_fwd_ok, mw_fwd_ok;

  assign em_fwd_ok = em_valid && em_wr && (em_op != OP_LOAD);
  assign mw_fwd_ok = mw_valid && mw_wr;

  assign ld_stall = fd_valid && de_valid && (de_op == OP_LOAD) &&
                    ((f_uses_rs1(fd_op) && fd_rs1 == de_rd) ||
                     (f_uses_rs2(fd_op) && fd_rs2 == de_rd));

  always_comb begin
    if (em_fwd_ok && em_rd == de_rs1)      opa = em_res;
    else if (mw_fwd_ok && mw_rd == de_rs1) opa = mw_val;
    else                                   opa = de_a;
    if (em_fwd_ok && em_rd == de_rs2)      opb = em_res;
    else if (mw_fwd_ok && mw_rd == de_rs2) opb = mw_val;
    else                                   opb = de_b;
  end
endmodule

// File: rtl/inord5_exec.sv
module inord5_exec
  import inord5_pkg::*;
(
  input  logic  valid,
  input  op_e   op,
  input  word_t a,
  input  word_t b,
  input  word_t imm,
  input  word_t pc,
  input  logic  zflag,
  output word_t result,
  output logic  redirect,
  output word_t target
);
  always_comb begin
    result   = f_alu(op, a, b, imm);
    redirect = 1'b0;
    target   = a + imm;
    case (op)
      OP_BAL:  begin result = pc + 32'd1; redirect = valid; end
      OP_JUMP: redirect = valid;
      OP_BZ:   begin target = pc + imm; redirect = valid && zflag; end
      OP_BNZ:  begin target = pc + imm; redirect = valid && !zflag; end
      default: ;
    endcase
  end
endmodule

// File: rtl/inord5_dmem.sv
module inord5_dmem #(
  parameter int DEPTH = 1024,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic        clk,
  input  logic        we,
  input  logic [31:0] addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  input  logic [31:0] dbg_addr,
  output logic [31:0] dbg_data
);
  logic [31:0] mem [DEPTH];
  logic in_rng, dbg_in_rng;

  assign in_rng     = addr < DEPTH;
  assign dbg_in_rng = dbg_addr < DEPTH;

  always_ff @(posedge clk) begin
    if (we && in_rng) mem[addr[AW-1:0]] <= wdata;
  end

  assign rdata    = in_rng ? mem[addr[AW-1:0]] : '0;
  assign dbg_data = dbg_in_rng ? mem[dbg_addr[AW-1:0]] : '0;
endmodule

// File: rtl/inord5_core.sv
module inord5_core
  import inord5_pkg::*;
#(
  parameter int          IMEM_WORDS = 256,
  parameter int          DMEM_WORDS = 1024,
  parameter logic [31:0] PC_BASE    = 32'd20000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        prog_we,
  input  logic [31:0] prog_addr,
  input  logic [31:0] prog_data,
  input  logic [2:0]  dbg_reg_sel,
  input  logic [31:0] dbg_mem_addr,
  output logic        halted,
  output logic [31:0] dbg_pc,
  output logic [31:0] dbg_reg_data,
  output logic [31:0] dbg_link,
  output logic [31:0] dbg_mem_data
);
  localparam int IAW = $clog2(IMEM_WORDS);

  // instruction storage
  word_t imem [IMEM_WORDS];
  always_ff @(posedge clk) begin
    if (prog_we && prog_addr < IMEM_WORDS) imem[prog_addr[IAW-1:0]] <= prog_data;
  end

  // pipeline state
  word_t pc_q;
  logic  fd_valid_q;  word_t fd_instr_q, fd_pc_q;
  logic  de_valid_q;  op_e de_op_q; logic [2:0] de_rd_q, de_rs1_q, de_rs2_q;
  word_t de_a_q, de_b_q, de_imm_q, de_pc_q;
  logic  em_valid_q, em_wr_q; op_e em_op_q; logic [2:0] em_rd_q;
  word_t em_res_q, em_sdata_q;
  logic  mw_valid_q, mw_wr_q; op_e mw_op_q; logic [2:0] mw_rd_q; word_t mw_val_q;
  logic  zflag_q, halt_seen_q, halted_q;
  word_t link_q;

  // named internal events
  logic  ex_redirect, ld_stall, fetch_hold, issue_halt, wb_we, mw_halt;
  word_t ex_target, ex_result, opa, opb, fetch_word, fetch_off, rf_a, rf_b, dm_rdata;

  op_e        fd_op;
  logic [2:0] fd_rd, fd_rs1, fd_rs2;
  assign fd_op  = f_op(fd_instr_q);
  assign fd_rd  = f_rd(fd_instr_q);
  assign fd_rs1 = f_rs1(fd_instr_q);
  assign fd_rs2 = f_rs2(fd_instr_q);

  assign fetch_off  = pc_q - PC_BASE;
  assign fetch_word = (fetch_off < IMEM_WORDS) ? imem[fetch_off[IAW-1:0]] : '0;

  assign wb_we      = mw_valid_q && mw_wr_q;
  assign mw_halt    = mw_valid_q && (mw_op_q == OP_HALT);
  assign fetch_hold = ld_stall || halt_seen_q || halted_q;
  assign issue_halt = fd_valid_q && (fd_op == OP_HALT) && !ex_redirect && !ld_stall;

  inord5_regfile #(.NREG(8), .W(32)) u_rf (
    .clk(clk), .rst_n(rst_n), .we(wb_we), .waddr(mw_rd_q), .wdata(mw_val_q),
    .raddr_a(fd_rs1), .raddr_b(fd_rs2), .rdata_a(rf_a), .rdata_b(rf_b),
    .dbg_sel(dbg_reg_sel), .dbg_data(dbg_reg_data)
  );

  inord5_hazard u_hz (
    .fd_valid(fd_valid_q), .fd_op(fd_op), .fd_rs1(fd_rs1), .fd_rs2(fd_rs2),
    .de_valid(de_valid_q), .de_op(de_op_q), .de_rd(de_rd_q),
    .de_rs1(de_rs1_q), .de_rs2(de_rs2_q), .de_a(de_a_q), .de_b(de_b_q),
    .em_valid(em_valid_q), .em_wr(em_wr_q), .em_op(em_op_q), .em_rd(em_rd_q),
    .em_res(em_res_q), .mw_valid(mw_valid_q), .mw_wr(mw_wr_q), .mw_rd(mw_rd_q),
    .mw_val(mw_val_q), .ld_stall(ld_stall), .opa(opa), .opb(opb)
  );

  inord5_exec u_ex (
    .valid(de_valid_q), .op(de_op_q), .a(opa), .b(opb), .imm(de_imm_q),
    .pc(de_pc_q), .zflag(zflag_q), .result(ex_result),
    .redirect(ex_redirect), .target(ex_target)
  );

  inord5_dmem #(.DEPTH(DMEM_WORDS)) u_dm (
    .clk(clk), .we(em_valid_q && em_op_q == OP_STORE), .addr(em_res_q),
    .wdata(em_sdata_q), .rdata(dm_rdata),
    .dbg_addr(dbg_mem_addr), .dbg_data(dbg_mem_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q        <= PC_BASE;
      fd_valid_q  <= 1'b0; fd_instr_q <= '0; fd_pc_q <= '0;
      de_valid_q  <= 1'b0; de_op_q <= OP_NOP; de_rd_q <= '0;
      de_rs1_q    <= '0;   de_rs2_q <= '0; de_a_q <= '0; de_b_q <= '0;
      de_imm_q    <= '0;   de_pc_q <= '0;
      em_valid_q  <= 1'b0; em_wr_q <= 1'b0; em_op_q <= OP_NOP; em_rd_q <= '0;
      em_res_q    <= '0;   em_sdata_q <= '0;
      mw_valid_q  <= 1'b0; mw_wr_q <= 1'b0; mw_op_q <= OP_NOP; mw_rd_q <= '0;
      mw_val_q    <= '0;
      zflag_q     <= 1'b0; halt_seen_q <= 1'b0; halted_q <= 1'b0;
      link_q      <= '0;
    end else begin
      // fetch
      if (ex_redirect)                    pc_q <= ex_target;
      else if (!fetch_hold && !issue_halt) pc_q <= pc_q + 32'd1;

      if (ex_redirect) begin
        fd_valid_q <= 1'b0;
      end else if (!ld_stall) begin
        if (halt_seen_q || halted_q || issue_halt) begin
          fd_valid_q <= 1'b0;
        end else begin
          fd_valid_q <= 1'b1;
          fd_instr_q <= fetch_word;
          fd_pc_q    <= pc_q;
        end
      end
      if (issue_halt) halt_seen_q <= 1'b1;

      // decode -> execute
      de_valid_q <= fd_valid_q && !ex_redirect && !ld_stall;
      de_op_q    <= fd_op;
      de_rd_q    <= fd_rd;
      de_rs1_q   <= fd_rs1;
      de_rs2_q   <= fd_rs2;
      de_a_q     <= rf_a;
      de_b_q     <= rf_b;
      de_imm_q   <= f_imm(fd_instr_q);
      de_pc_q    <= fd_pc_q;

      // execute -> memory
      em_valid_q <= de_valid_q;
      em_op_q    <= de_op_q;
      em_rd_q    <= de_rd_q;
      em_wr_q    <= f_writes(de_op_q);
      em_res_q   <= ex_result;
      em_sdata_q <= opb;
      if (de_valid_q && f_is_alu(de_op_q)) zflag_q <= (ex_result == '0);

      // memory -> writeback
      mw_valid_q <= em_valid_q;
      mw_op_q    <= em_op_q;
      mw_rd_q    <= em_rd_q;
      mw_wr_q    <= em_wr_q;
      mw_val_q   <= (em_op_q == OP_LOAD) ? dm_rdata : em_res_q;

      // writeback side effects
      if (mw_valid_q && mw_op_q == OP_BAL) link_q <= mw_val_q;
      if (mw_halt) halted_q <= 1'b1;
    end
  end

  assign halted   = halted_q;
  assign dbg_pc   = pc_q;
  assign dbg_link = link_q;
endmodule

// File: rtl/inord5_chk.sv
module inord5_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        halted,
  input logic [31:0] dbg_pc,
  input logic        ex_redirect,
  input logic        ld_stall,
  input logic        fetch_hold,
  input logic        issue_halt,
  input logic        fd_valid,
  input logic        de_valid,
  input logic        wb_we,
  input logic        mw_halt
);
  AST_SEQ_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    (!fetch_hold && !ex_redirect && !issue_halt) |=> dbg_pc == $past(dbg_pc) + 32'd1); // R2

  AST_STALL_BUBBLE: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_stall && !ex_redirect) |=> (!de_valid && $stable(dbg_pc))); // R6

  AST_REDIRECT_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    ex_redirect |=> (!fd_valid && !de_valid)); // R8

  AST_HALT_AT_WB: assert property (@(posedge clk) disable iff (!rst_n)
    mw_halt |=> halted); // R10

  AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> (halted && $stable(dbg_pc))); // R10

  AST_NO_WB_AFTER_HALT: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !wb_we); // R10
endmodule

bind inord5_core inord5_chk u_chk (
  .clk(clk), .rst_n(rst_n), .halted(halted), .dbg_pc(dbg_pc),
  .ex_redirect(ex_redirect), .ld_stall(ld_stall), .fetch_hold(fetch_hold),
  .issue_halt(issue_halt), .fd_valid(fd_valid_q), .de_valid(de_valid_q),
  .wb_we(wb_we), .mw_halt(mw_halt)
);

// File: tb/inord5_core_tb.sv
`timescale 1ns/1ps
module inord5_core_tb;
  localparam int BASE = 20000;
  localparam int DMW  = 1024;
  localparam int NOP_ = 0, ADD = 1, SUB = 2, MOVC = 3, MUL = 4, AND_ = 5, OR_ = 6,
                 XOR_ = 7, LOAD = 8, STORE = 9, BZ = 10, BNZ = 11, JUMP = 12,
                 BAL = 13, HALT = 14;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic prog_we = 1'b0;
  logic [31:0] prog_addr = '0, prog_data = '0, dbg_mem_addr = '0;
  logic [2:0]  dbg_reg_sel = '0;
  logic        halted;
  logic [31:0] dbg_pc, dbg_reg_data, dbg_link, dbg_mem_data;

  always #2.5 clk = ~clk;

  inord5_core u_dut (
    .clk(clk), .rst_n(rst_n), .prog_we(prog_we), .prog_addr(prog_addr),
    .prog_data(prog_data), .dbg_reg_sel(dbg_reg_sel), .dbg_mem_addr(dbg_mem_addr),
    .halted(halted), .dbg_pc(dbg_pc), .dbg_reg_data(dbg_reg_data),
    .dbg_link(dbg_link), .dbg_mem_data(dbg_mem_data)
  );

  int n_run = 0, n_fail = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
    end
  endtask

  // program under construction
  logic [31:0] prog [256];
  int plen;

  task automatic clear_prog();
    for (int i = 0; i < 256; i++) prog[i] = '0;
    plen = 0;
  endtask

  task automatic emit(input int op, input int rd, input int rs1, input int rs2, input int imm);
    prog[plen] = {op[4:0], rd[2:0], rs1[2:0], rs2[2:0], 2'b00, imm[15:0]};
    plen++;
  endtask

  // instruction-level reference model
  logic [31:0] m_reg [8];
  logic [31:0] m_mem [DMW];
  bit          m_wr  [DMW];
  logic [31:0] m_x, m_pc_end;
  int m_n, m_stall, m_taken;

  task automatic run_model();
    logic [31:0] pc, w, a, b, imm, addr;
    int op, rd, r1, r2, prev_rd;
    bit z, prev_ld, u1, u2;
    for (int i = 0; i < 8; i++) m_reg[i] = '0;
    for (int i = 0; i < DMW; i++) m_wr[i] = 0;
    m_x = '0; pc = BASE; z = 0; prev_ld = 0; prev_rd = 0;
    m_n = 0; m_stall = 0; m_taken = 0;
    while (m_n < 1000) begin
      w = (pc - BASE < 256) ? prog[pc - BASE] : '0;
      op = int'(w[31:27]); rd = int'(w[26:24]); r1 = int'(w[23:21]); r2 = int'(w[20:18]);
      if (op > 14) op = NOP_;
      imm = {{16{w[15]}}, w[15:0]};
      a = m_reg[r1]; b = m_reg[r2];
      m_n++;
      u1 = (op >= ADD && op <= STORE && op != MOVC) || op == JUMP || op == BAL;
      u2 = (op >= ADD && op <= XOR_ && op != MOVC) || op == STORE;
      if (prev_ld && ((u1 && r1 == prev_rd) || (u2 && r2 == prev_rd))) m_stall++;
      prev_ld = (op == LOAD); prev_rd = rd;
      addr = a + imm;
      case (op)
        ADD:  begin m_reg[rd] = a + b;   z = (m_reg[rd] == 0); end
        SUB:  begin m_reg[rd] = a - b;   z = (m_reg[rd] == 0); end
        MOVC: begin m_reg[rd] = imm;     z = (m_reg[rd] == 0); end
        MUL:  begin m_reg[rd] = a * b;   z = (m_reg[rd] == 0); end
        AND_: begin m_reg[rd] = a & b;   z = (m_reg[rd] == 0); end
        OR_:  begin m_reg[rd] = a | b;   z = (m_reg[rd] == 0); end
        XOR_: begin m_reg[rd] = a ^ b;   z = (m_reg[rd] == 0); end
        LOAD: m_reg[rd] = (addr < DMW) ? m_mem[addr] : '0;
        STORE: if (addr < DMW) begin m_mem[addr] = b; m_wr[addr] = 1; end
        default: ;
      endcase
      if (op == HALT) begin m_pc_end = pc + 1; break; end
      if ((op == BZ && z) || (op == BNZ && !z)) begin pc = pc + imm; m_taken++; end
      else if (op == JUMP) begin pc = addr; m_taken++; end
      else if (op == BAL) begin m_x = pc + 1; pc = addr; m_taken++; end
      else pc = pc + 1;
    end
  endtask

  task automatic run_dut(input string tag_t, input int base_c);
    int cyc;
    @(negedge clk); rst_n = 1'b0;
    for (int i = 0; i < plen; i++) begin
      @(negedge clk); prog_we = 1'b1; prog_addr = i; prog_data = prog[i];
    end
    @(negedge clk); prog_we = 1'b0;
    // R1 reset state
    dbg_reg_sel = 3'd5; #0.5;
    chk(dbg_pc == BASE, "R1", "pc in reset", dbg_pc, BASE);
    chk(halted == 1'b0, "R1", "halted in reset", {31'd0, halted}, 0);
    chk(dbg_reg_data == 0 && dbg_link == 0, "R1", "r5/link in reset", dbg_reg_data | dbg_link, 0);
    run_model();
    @(negedge clk); rst_n = 1'b1;
    cyc = 0;
    while (cyc < 3000) begin
      @(posedge clk); cyc++;
      @(negedge clk);
      if (halted) break;
    end
    if (tag_t == "P1")
      chk(cyc == m_n + 4 + m_stall + 2 * m_taken, "R6", "cycles to halt", cyc,
          m_n + 4 + m_stall + 2 * m_taken);
    else
      chk(cyc == m_n + 4 + m_stall + 2 * m_taken, "R8", "cycles to halt", cyc,
          m_n + 4 + m_stall + 2 * m_taken);
    // results read after every stage has drained
    repeat (2) @(negedge clk);
    chk(halted == 1'b1, "R10", "halted sticky", {31'd0, halted}, 1);
    chk(dbg_pc == m_pc_end, "R10", "pc after halt", dbg_pc, m_pc_end);
    for (int r = 0; r < 8; r++) begin
      dbg_reg_sel = r[2:0]; #0.5;
      if (tag_t == "P1") chk(dbg_reg_data == m_reg[r], "R3", $sformatf("P1 r%0d", r), dbg_reg_data, m_reg[r]);
      else               chk(dbg_reg_data == m_reg[r], "R7", $sformatf("P2 r%0d", r), dbg_reg_data, m_reg[r]);
    end
    chk(dbg_link == m_x, "R9", "link register", dbg_link, m_x);
    for (int k = 0; k < 4; k++) begin
      dbg_mem_addr = base_c + k; #0.5;
      if (m_wr[base_c + k])
        chk(dbg_mem_data == m_mem[base_c + k], "R4", $sformatf("mem[%0d]", base_c + k),
            dbg_mem_data, m_mem[base_c + k]);
    end
  endtask

  // P1: ALU sweep with back-to-back dependencies (R5) and load-use pairs (R6)
  task automatic build_p1(input int a, input int b, input int c);
    clear_prog();
    emit(MOVC, 1, 0, 0, a);
    emit(MOVC, 2, 0, 0, b);
    emit(ADD, 3, 1, 2, 0);
    emit(SUB, 4, 3, 1, 0);
    emit(MUL, 5, 3, 4, 0);
    emit(AND_, 6, 5, 2, 0);
    emit(OR_, 7, 6, 4, 0);
    emit(XOR_, 0, 7, 5, 0);
    emit(MUL, 5, 5, 5, 0);
    emit(MOVC, 1, 0, 0, c);
    emit(STORE, 0, 1, 3, 0);
    emit(STORE, 0, 1, 4, 1);
    emit(STORE, 0, 1, 5, 2);
    emit(LOAD, 2, 1, 0, 1);
    emit(ADD, 6, 2, 2, 0);
    emit(LOAD, 7, 1, 0, 2);
    emit(STORE, 0, 1, 7, 3);
    emit(SUB, 0, 0, 7, 0);
    emit(HALT, 0, 0, 0, 0);
    emit(MOVC, 1, 0, 0, 777);
    emit(MOVC, 3, 0, 0, 888);
  endtask

  // P2: conditional branches, branch-and-link, jump, halt with younger code
  task automatic build_p2(input int x);
    clear_prog();
    emit(MOVC, 1, 0, 0, x);     // 0
    emit(BZ, 0, 0, 0, 3);       // 1 -> 4
    emit(MOVC, 2, 0, 0, 11);    // 2
    emit(MOVC, 3, 0, 0, 22);    // 3
    emit(BNZ, 0, 0, 0, 2);      // 4 -> 6
    emit(MOVC, 4, 0, 0, 33);    // 5
    emit(MOVC, 5, 0, 0, BASE);  // 6
    emit(BAL, 0, 5, 0, 12);     // 7 -> 12
    emit(MOVC, 6, 0, 0, 44);    // 8
    emit(MOVC, 7, 0, 0, 55);    // 9
    emit(HALT, 0, 0, 0, 0);     // 10
    emit(NOP_, 0, 0, 0, 0);     // 11
    emit(ADD, 6, 1, 5, 0);      // 12
    emit(JUMP, 0, 5, 0, 16);    // 13 -> 16
    emit(MOVC, 7, 0, 0, 66);    // 14
    emit(MOVC, 0, 0, 0, 77);    // 15
    emit(MOVC, 7, 0, 0, 88);    // 16
    emit(HALT, 0, 0, 0, 0);     // 17
    emit(MOVC, 0, 0, 0, 99);    // 18
  endtask

  int av [6] = '{0, 1, -1, 32767, -32768, 7};
  int bv [4] = '{0, -1, 3, 12345};
  int xv [3] = '{0, 1, -5};

  initial begin
    for (int i = 0; i < 6; i++) begin
      for (int j = 0; j < 4; j++) begin
        build_p1(av[i], bv[j], (i * 4 + j) * 37 % 1000);
        run_dut("P1", (i * 4 + j) * 37 % 1000);
      end
    end
    for (int i = 0; i < 3; i++) begin
      build_p2(xv[i]);
      run_dut("P2", 0);
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(5.0 * 190000);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected halt");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule